// File: doc/BRIEF.md
# 32x Oversampling Bit-Clock Recovery

This block recovers a bit-rate clock for a synchronous serial receiver from a reference clock that runs at 32 times the bit rate. A 5-bit phase counter steps once per reference cycle and spans one bit period. The recovered clock is high for the upper half of the count. Its rising edge marks the mid-bit sampling instant and its falling edge (the counter wrap) marks the instant a transmitter launches its next bit. The incoming serial data is synchronised into the reference domain and watched for transitions. The first transition of a frame snaps the counter into phase. Every later transition nudges the counter by at most one count, or leaves it alone when the transition is close enough to the bit boundary.

A bypass mode serves links that deliver a clock at the bit rate. Here the counter is idle. The receive sample strobe follows the rising edges of an external 1x receive clock, and the transmit enable follows the falling edges of an external 1x transmit clock. Both clocks are synchronised into the reference domain first. A frame-start input, driven by the flag/idle detector of the surrounding receiver, re-arms the snap-to-phase behaviour for the next frame.

The control is a three-state machine:
- BYPASS: 1x mode, counter held at 0.
- HUNT: 32x mode, counter free-running, waiting for the first transition.
- TRACK: 32x mode, applying single-count corrections.

The transitions are:
- any state to BYPASS when `mode_32x` is low (DROP_TO_BYPASS)
- BYPASS to HUNT when `mode_32x` is high (ARM)
- HUNT to TRACK on a synchronised data transition (SNAP)
- TRACK to HUNT on `frame_start` (REARM)

Top module: `dpll_clk_recover`

## Requirements
- R1: While `rst_n` is low, `bit_clk`, `sample_en` and `tx_en` are 0, and the machine is in BYPASS with the counter at 0.
- R2: In 32x mode with no data transitions, `bit_clk` is high for 16 and low for 16 of every 32 reference cycles. `sample_en` pulses for one cycle in the cycle `bit_clk` rises. `tx_en` pulses for one cycle in the cycle `bit_clk` falls. Both pulses repeat every 32 cycles.
- R3: `rx_data` is registered twice in the reference domain, and a transition is flagged when the second register differs from a third. In HUNT, a flagged transition forces the counter to 1 and enters TRACK. A level change on `rx_data` first captured at clock edge k therefore sets the count to 1 at edge k+2, and `sample_en` rises at edge k+17.
- R4: In TRACK, a transition flagged while the count is in 3..15 (counter behind) advances the counter by 2 instead of 1. The bit period that contains it shortens to 31 cycles.
- R5: In TRACK, a transition flagged while the count is in 17..29 (counter ahead) holds the count for one cycle. The bit period that contains it lengthens to 33 cycles.
- R6: In TRACK, a transition flagged at counts 30, 31, 0, 1, 2 (dead zone) or at 16 causes no correction, and the bit period stays 32 cycles.
- R7: `frame_start` high in TRACK returns the machine to HUNT, so the next transition forces the count to 1 again. If `frame_start` and a flagged transition occur in the same cycle in TRACK, `frame_start` wins and no correction is applied.
- R8: With `mode_32x` low, `bit_clk` follows `rx_clk_1x` after a two-register synchroniser and one output register. `sample_en` pulses once per rising edge of `rx_clk_1x`, and `tx_en` pulses once per falling edge of `tx_clk_1x`, each with the same latency of three clock edges.
- R9: Transitions on `rx_data` have no effect in BYPASS. After `mode_32x` goes high, the counter restarts from 0 in HUNT, so the first `sample_en` comes 17 cycles after the mode change if no transition arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, 32x the bit rate in 32x mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_32x | input | 1 | 1: oversampling recovery, 0: external 1x clock bypass |
| frame_start | input | 1 | Re-arms the first-transition snap (from flag/idle detection) |
| rx_data | input | 1 | Received serial data, asynchronous to clk_ref |
| rx_clk_1x | input | 1 | External 1x receive clock, used in bypass |
| tx_clk_1x | input | 1 | External 1x transmit clock, used in bypass |
| bit_clk | output | 1 | Recovered bit clock |
| sample_en | output | 1 | One-cycle strobe at the mid-bit sample point |
| tx_en | output | 1 | One-cycle strobe at the transmit bit launch point |

## Verification
The bench builds the block with its default parameters: a 5-bit counter, a dead zone of two counts on each side of the wrap, and two synchroniser stages. With these values every one of the 32 counter positions can be reached in a single bit period. The bench places a data transition at each of the 32 positions in turn and measures the length of the bit that contains it. This covers both correction windows, the whole dead zone and the lone mid-bit position. Directed sequences also cover the snap from HUNT, re-arming, the same-cycle precedence of frame start over a correction, and both directions of the mode switch.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_HUNT   = 2'd1,
        ST_TRACK  = 2'd2
    } dpll_state_e;

    typedef enum logic [1:0] {
        PH_DEAD  = 2'd0,
        PH_LATE  = 2'd1,
        PH_EARLY = 2'd2
    } phase_zone_e;

    typedef enum logic [1:0] {
        EDGE_ANY  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;

    // Classify where in the bit period a transition was seen.
    // Late (counter behind): just after the dead zone up to one before mid-bit.
    // Early (counter ahead): one after mid-bit up to the start of the dead zone.
    function automatic phase_zone_e zone_of(input int unsigned pos,
                                            input int unsigned period,
                                            input int unsigned dead);
        int unsigned half;
        half = period / 2;
        if (pos > dead && pos < half)
            return PH_LATE;
        else if (pos > half && pos < period - dead)
            return PH_EARLY;
        else
            return PH_DEAD;
    endfunction

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/dpll_edge_det.sv
module dpll_edge_det #(
    parameter dpll_pkg::edge_kind_e KIND = dpll_pkg::EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    if (KIND == dpll_pkg::EDGE_RISE) begin : g_rise
        assign pulse = level & ~prev_q;
    end else if (KIND == dpll_pkg::EDGE_FALL) begin : g_fall
        assign pulse = ~level & prev_q;
    end else begin : g_any
        assign pulse = level ^ prev_q;
    end

endmodule

// File: rtl/dpll_phase_ctrl.sv
module dpll_phase_ctrl
    import dpll_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int DEAD  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_32x,
    input  logic frame_start,
    input  logic data_edge,
    input  logic rxc_level,
    input  logic rxc_rise,
    input  logic txc_fall,
    output logic bit_clk,
    output logic sample_en,
    output logic tx_en
);
    localparam int PERIOD = 1 << CNT_W;
    localparam int MSB    = CNT_W - 1;

    dpll_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    phase_zone_e      zone;

    assign zone = zone_of(32'(cnt), PERIOD, DEAD);

    // next state and next count
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        if (!mode_32x) begin
            state_nx = ST_BYPASS;          // DROP_TO_BYPASS
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_BYPASS: begin
                    state_nx = ST_HUNT;    // ARM
                    cnt_nx   = '0;
                end
                ST_HUNT: begin
                    if (data_edge) begin
                        state_nx = ST_TRACK;   // SNAP
                        cnt_nx   = CNT_W'(1);
                    end
                end
                ST_TRACK: begin
                    if (frame_start) begin
                        state_nx = ST_HUNT;    // REARM, no correction
                    end else if (data_edge) begin
                        case (zone)
                            PH_LATE:  cnt_nx = cnt + CNT_W'(2);
                            PH_EARLY: cnt_nx = cnt;
                            default:  cnt_nx = cnt + 1'b1;
                        endcase
                    end
                end
                default: begin
                    state_nx = ST_BYPASS;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BYPASS;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_clk   <= 1'b0;
            sample_en <= 1'b0;
            tx_en     <= 1'b0;
        end else if (!mode_32x) begin
            bit_clk   <= rxc_level;
            sample_en <= rxc_rise;
            tx_en     <= txc_fall;
        end else begin
            bit_clk   <= cnt_nx[MSB];
            sample_en <= ~cnt[MSB] & cnt_nx[MSB];
            tx_en     <= cnt[MSB] & ~cnt_nx[MSB];
        end
    end

    // R3: first transition in HUNT snaps the count to 1
    a_r3_snap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && mode_32x && data_edge) |=> (cnt == CNT_W'(1) && state == ST_TRACK));

    // R4: late transition skips one count
    a_r4_late_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && mode_32x && !frame_start && data_edge && zone == PH_LATE)
        |=> (cnt == $past(cnt) + CNT_W'(2)));

    // R5: early transition holds the count
    a_r5_early_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && mode_32x && !frame_start && data_edge && zone == PH_EARLY)
        |=> (cnt == $past(cnt)));

    // R7: frame start returns the machine to HUNT
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && mode_32x && frame_start) |=> (state == ST_HUNT));

    // R9: counter is parked at zero in bypass
    a_r9_bypass_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> (cnt == '0));

endmodule

// File: rtl/dpll_clk_recover.sv
module dpll_clk_recover
    import dpll_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int DEAD        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic mode_32x,
    input  logic frame_start,
    input  logic rx_data,
    input  logic rx_clk_1x,
    input  logic tx_clk_1x,
    output logic bit_clk,
    output logic sample_en,
    output logic tx_en
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] async_in, synced;
    logic            data_edge, rxc_rise, txc_fall;

    assign async_in = {tx_clk_1x, rx_clk_1x, rx_data};

    dpll_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (synced)
    );

    dpll_edge_det #(.KIND(EDGE_ANY)) u_data_edge (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .level (synced[0]),
        .pulse (data_edge)
    );

    dpll_edge_det #(.KIND(EDGE_RISE)) u_rxc_edge (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .level (synced[1]),
        .pulse (rxc_rise)
    );

    dpll_edge_det #(.KIND(EDGE_FALL)) u_txc_edge (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .level (synced[2]),
        .pulse (txc_fall)
    );

    dpll_phase_ctrl #(.CNT_W(CNT_W), .DEAD(DEAD)) u_ctrl (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .mode_32x    (mode_32x),
        .frame_start (frame_start),
        .data_edge   (data_edge),
        .rxc_level   (synced[1]),
        .rxc_rise    (rxc_rise),
        .txc_fall    (txc_fall),
        .bit_clk     (bit_clk),
        .sample_en   (sample_en),
        .tx_en       (tx_en)
    );

    // R2: the sample strobe only ever appears while the bit clock is high
    a_r2_sample_in_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
        sample_en |-> bit_clk);

endmodule

// File: tb/dpll_clk_recover_test.sv
module dpll_clk_recover_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_32x = 1'b1;
    logic frame_start = 1'b0;
    logic rx_data = 1'b0;
    logic rx_clk_1x = 1'b0;
    logic tx_clk_1x = 1'b0;
    logic bit_clk, sample_en, tx_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_clk_recover uut (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .mode_32x    (mode_32x),
        .frame_start (frame_start),
        .rx_data     (rx_data),
        .rx_clk_1x   (rx_clk_1x),
        .tx_clk_1x   (tx_clk_1x),
        .bit_clk     (bit_clk),
        .sample_en   (sample_en),
        .tx_en       (tx_en)
    );

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int last_te = -1000;
    bit finished = 1'b0;
    string tag = "R1";

    // behavioural reference model
    int m_d1, m_d2, m_d3, m_r1, m_r2, m_r3, m_t1, m_t2, m_t3;
    int m_cnt, m_st;               // 0 bypass, 1 hunt, 2 track
    bit m_bclk, m_se, m_te;

    always @(posedge clk or negedge rst_n) begin
        int nx, nst;
        bit chg;
        if (!rst_n) begin
            m_d1 = 0; m_d2 = 0; m_d3 = 0;
            m_r1 = 0; m_r2 = 0; m_r3 = 0;
            m_t1 = 0; m_t2 = 0; m_t3 = 0;
            m_cnt = 0; m_st = 0;
            m_bclk = 0; m_se = 0; m_te = 0;
        end else begin
            chg = (m_d2 != m_d3);
            nst = m_st;
            nx  = (m_cnt + 1) % 32;
            if (!mode_32x) begin
                nst = 0; nx = 0;
            end else if (m_st == 0) begin
                nst = 1; nx = 0;
            end else if (m_st == 1) begin
                if (chg) begin nst = 2; nx = 1; end
            end else begin
                if (frame_start) nst = 1;
                else if (chg) begin
                    if (m_cnt >= 3 && m_cnt <= 15) nx = (m_cnt + 2) % 32;
                    else if (m_cnt >= 17 && m_cnt <= 29) nx = m_cnt;
                end
            end
            if (!mode_32x) begin
                m_bclk = (m_r2 != 0);
                m_se   = (m_r2 != 0) && (m_r3 == 0);
                m_te   = (m_t2 == 0) && (m_t3 != 0);
            end else begin
                m_bclk = (nx >= 16);
                m_se   = (m_cnt < 16) && (nx >= 16);
                m_te   = (m_cnt >= 16) && (nx < 16);
            end
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = int'(rx_data);
            m_r3 = m_r2; m_r2 = m_r1; m_r1 = int'(rx_clk_1x);
            m_t3 = m_t2; m_t2 = m_t1; m_t1 = int'(tx_clk_1x);
            m_cnt = nx;
            m_st  = nst;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (tx_en === 1'b1) last_te = cyc;
        checks++;
        if (bit_clk !== m_bclk || sample_en !== m_se || tx_en !== m_te) begin
            bad++;
            $display("FAIL %s cycle %0d: bit_clk/sample_en/tx_en actual=%b%b%b expected=%b%b%b",
                     tag, cyc, bit_clk, sample_en, tx_en, m_bclk, m_se, m_te);
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cnt(input int c);
        do tick(); while (m_cnt != c);
    endtask

    task automatic wait_se(output int at);
        do tick(); while (sample_en !== 1'b1);
        at = cyc;
    endtask

    task automatic wait_te(output int at);
        do tick(); while (tx_en !== 1'b1);
        at = cyc;
    endtask

    initial begin
        int a, b, t0, prev, nxt, hi, n_se, n_te, n_rise, n_fall;
        // R1: reset state
        repeat (3) tick();
        chk("R1", "bit_clk in reset", int'(bit_clk), 0);
        chk("R1", "sample_en in reset", int'(sample_en), 0);
        chk("R1", "tx_en in reset", int'(tx_en), 0);
        rst_n = 1'b1;

        // R2: free run in HUNT
        tag = "R2";
        wait_se(a);
        wait_se(b);
        chk("R2", "sample_en period", b - a, 32);
        hi = 0;
        for (int i = 0; i < 32; i++) begin
            if (bit_clk === 1'b1) hi++;
            tick();
        end
        chk("R2", "bit_clk high cycles", hi, 16);
        wait_te(a);
        wait_te(b);
        chk("R2", "tx_en period", b - a, 32);

        // R3: first transition snaps the count to 1
        tag = "R3";
        wait_cnt(5);
        rx_data = ~rx_data;
        t0 = cyc;
        wait_se(a);
        chk("R3", "cycles from first transition to sample_en", a - t0, 18);

        // R4, R5, R6: transition at every counter position
        for (int p = 0; p < 32; p++) begin
            int exp;
            string req;
            if (p >= 3 && p <= 15) begin exp = 31; req = "R4"; end
            else if (p >= 17 && p <= 29) begin exp = 33; req = "R5"; end
            else begin exp = 32; req = "R6"; end
            tag = req;
            wait_cnt((p + 30) % 32);
            rx_data = ~rx_data;
            tick();
            tick();
            prev = last_te;
            wait_te(nxt);
            chk(req, $sformatf("bit length with transition at count %0d", p), nxt - prev, exp);
        end

        // R7: frame start re-arms the snap
        tag = "R7";
        wait_cnt(8);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        wait_cnt(8);
        rx_data = ~rx_data;
        t0 = cyc;
        wait_se(a);
        chk("R7", "snap after frame start", a - t0, 18);

        // R7: frame start wins over a same-cycle correction
        wait_cnt(8);
        rx_data = ~rx_data;
        t0 = cyc;
        tick();
        tick();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        wait_se(a);
        chk("R7", "no correction when frame start coincides", a - t0, 8);
        wait_cnt(8);
        rx_data = ~rx_data;
        t0 = cyc;
        wait_se(a);
        chk("R7", "snap after coincident frame start", a - t0, 18);

        // R8 and R9: bypass with external 1x clocks, data toggles ignored
        tag = "R8";
        wait_cnt(20);
        mode_32x = 1'b0;
        n_se = 0; n_te = 0; n_rise = 0; n_fall = 0;
        for (int i = 0; i < 124; i++) begin
            tick();
            if (sample_en === 1'b1) n_se++;
            if (tx_en === 1'b1) n_te++;
            if (i < 120) begin
                if (i % 4 == 0) begin
                    rx_clk_1x = ~rx_clk_1x;
                    if (rx_clk_1x) n_rise++;
                end
                if (i % 5 == 0) begin
                    tx_clk_1x = ~tx_clk_1x;
                    if (!tx_clk_1x) n_fall++;
                end
                if (i % 7 == 0) rx_data = ~rx_data;
            end
        end
        chk("R8", "sample_en pulses vs rx clock rises", n_se, n_rise);
        chk("R8", "tx_en pulses vs tx clock falls", n_te, n_fall);

        tag = "R9";
        mode_32x = 1'b1;
        t0 = cyc;
        wait_se(a);
        chk("R9", "first sample_en after leaving bypass", a - t0, 17);
        wait_se(b);
        chk("R9", "period after leaving bypass", b - a, 32);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not complete, tag %s", tag);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule